// File: doc/BRIEF.md
# FSK Tone Generator

The block turns a stream of symbol values into a frequency-shift-keyed sine wave for a digital-to-analog converter. A phase accumulator gains a programmable step on every enabled clock. The symbol present at that edge picks the step from a small table of per-symbol phase increments, so each symbol value produces its own output frequency. The top bits of the accumulator address a single-period sine lookup held in block memory, and the lookup output is the sample word.

A symbol change alters only the step size. The accumulator is never cleared on a symbol change, so the waveform moves from one frequency to the next without a phase jump. The symbol index may be one bit (binary keying) or several bits, so a band of up to 256 tones can carry multi-bit symbols. The increment table is loaded through a simple write port. When enable is low, the waveform stops where it is and the output word reads zero. The design targets a 100 MHz sample clock.

Top module: `fsk_tone_gen`

## Requirements
- R1: While rst_i is high at a clock edge, the accumulator is cleared to 0 and, after that edge, valid_o is 0 and sample_o is 0.
- R2: When en_i is high at an edge, valid_o is 1 after that edge, and sample_o holds the sine code addressed by the top ADDR_W (10) bits of the accumulator value from before that edge.
- R3: At every edge with en_i high, the accumulator becomes its old value plus the increment selected by sym_i, modulo 2^PHASE_W (32 bits). A step such as 0xFFC00000 therefore walks the table backwards.
- R4: A new sym_i value sets the step from the edge at which it is sampled. The accumulator is not reset, so the next sample continues from the current phase.
- R5: At an edge with en_i low, the accumulator keeps its value and, after that edge, valid_o is 0 and sample_o is 0.
- R6: A write (tbl_we_i high) stores tbl_step_i into table entry tbl_sel_i at that edge. The new value is used from the following edge on. An accumulator step taken at the same edge uses the old entry. All entries reset to 0.
- R7: The table has 2^SYM_W entries. Entry k is used when sym_i equals k, and each entry keeps its own value independently of the others.
- R8: Table entry k holds round(A*sin(2*pi*k/2^ADDR_W)) to within 1 LSB, with A = 2^(SAMPLE_W-1)-1 (8191), coded in two's complement on SAMPLE_W (14) bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Run enable; low freezes phase and zeroes output |
| sym_i | input | SYM_W | Current symbol index |
| tbl_we_i | input | 1 | Increment table write strobe |
| tbl_sel_i | input | SYM_W | Table entry to write |
| tbl_step_i | input | PHASE_W | Phase increment to store |
| valid_o | output | 1 | Sample word is live |
| sample_o | output | SAMPLE_W | Signed sine sample |

## Verification
Each enabled edge has two effects. It advances the phase at once, and it produces the sample for the pre-advance phase one edge later, because the ROM is read synchronously. A table write takes effect on the edge after it, and an enable drop zeroes the output one edge after it is sampled. The bench drives inputs on the falling edge. It updates a behavioural phase and table model on the rising edge in that same order, and compares valid_o and sample_o at the next falling edge, exactly one register stage after the stimulus. Sample values are compared against a real-valued sine with one LSB of tolerance.

// File: rtl/fsk_pkg.sv
package fsk_pkg;

    // pi/2 in Q2.30
    localparam longint HALF_PI_Q30 = 64'sd1686629713;

    // Sine code for table index idx of a depth-entry period, peak amplitude amp.
    // Quarter-wave symmetry plus an odd Taylor series in Q30 fixed point.
    function automatic int sine_code(input int unsigned idx,
                                     input int unsigned depth,
                                     input int unsigned amp);
        int unsigned quarter;
        int unsigned quad;
        int unsigned rem;
        int unsigned pos;
        longint      x;
        longint      x2;
        longint      term;
        longint      sum;
        longint      mag;
        quarter = depth / 4;
        quad    = (idx / quarter) % 4;
        rem     = idx % quarter;
        pos     = (quad == 1 || quad == 3) ? (quarter - rem) : rem;
        x       = (longint'(pos) * HALF_PI_Q30) / longint'(quarter);
        x2      = (x * x) >>> 30;
        term    = x;
        sum     = x;
        for (int k = 1; k <= 5; k++) begin
            term = -((term * x2) >>> 30) / longint'((2 * k) * (2 * k + 1));
            sum  = sum + term;
        end
        mag = (sum * longint'(amp) + (longint'(1) <<< 29)) >>> 30;
        return (quad >= 2) ? -int'(mag) : int'(mag);
    endfunction

endpackage

// File: rtl/fsk_inc_table.sv
module fsk_inc_table #(
    parameter int SYM_W   = 2,
    parameter int PHASE_W = 32
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               we_i,
    input  logic [SYM_W-1:0]   wsel_i,
    input  logic [PHASE_W-1:0] wdata_i,
    input  logic [SYM_W-1:0]   rsel_i,
    output logic [PHASE_W-1:0] step_o
);
    localparam int NSYM = 1 << SYM_W;

    typedef logic [PHASE_W-1:0] word_t;

    word_t tab_d [NSYM];
    word_t tab_q [NSYM];

    always_comb begin
        for (int i = 0; i < NSYM; i++) begin
            tab_d[i] = tab_q[i];
        end
        if (we_i) begin
            tab_d[wsel_i] = wdata_i;
        end
    end

    always_ff @(posedge clk_i) begin
        for (int i = 0; i < NSYM; i++) begin
            if (rst_i) begin
                tab_q[i] <= '0;
            end else begin
                tab_q[i] <= tab_d[i];
            end
        end
    end

    assign step_o = tab_q[rsel_i];

endmodule

// File: rtl/fsk_phase_acc.sv
module fsk_phase_acc #(
    parameter int PHASE_W = 32
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               en_i,
    input  logic [PHASE_W-1:0] step_i,
    output logic [PHASE_W-1:0] acc_o
);
    typedef struct packed {
        logic [PHASE_W-1:0] acc;
    } acc_st_t;

    acc_st_t st_d;
    acc_st_t st_q;

    always_comb begin
        st_d = st_q;
        if (en_i) begin
            st_d.acc = st_q.acc + step_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_o = st_q.acc;

endmodule

// File: rtl/fsk_sine_rom.sv
module fsk_sine_rom #(
    parameter int ADDR_W   = 10,
    parameter int SAMPLE_W = 14
) (
    input  logic                       clk_i,
    input  logic [ADDR_W-1:0]          addr_i,
    output logic signed [SAMPLE_W-1:0] data_o
);
    localparam int          DEPTH = 1 << ADDR_W;
    localparam int unsigned AMP   = (1 << (SAMPLE_W - 1)) - 1;

    typedef logic signed [SAMPLE_W-1:0] sample_t;

    sample_t rom [DEPTH];
    sample_t data_q;

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            rom[i] = sample_t'(fsk_pkg::sine_code(i, DEPTH, AMP));
        end
    end

    always_ff @(posedge clk_i) begin
        data_q <= rom[addr_i];
    end

    assign data_o = data_q;

endmodule

// File: rtl/fsk_tone_gen.sv
module fsk_tone_gen #(
    parameter int SYM_W    = 2,
    parameter int PHASE_W  = 32,
    parameter int ADDR_W   = 10,
    parameter int SAMPLE_W = 14
) (
    input  logic                       clk_i,
    input  logic                       rst_i,
    input  logic                       en_i,
    input  logic [SYM_W-1:0]           sym_i,
    input  logic                       tbl_we_i,
    input  logic [SYM_W-1:0]           tbl_sel_i,
    input  logic [PHASE_W-1:0]         tbl_step_i,
    output logic                       valid_o,
    output logic signed [SAMPLE_W-1:0] sample_o
);
    typedef struct packed {
        logic valid;
    } out_st_t;

    logic [PHASE_W-1:0]         step_w;
    logic [PHASE_W-1:0]         acc_w;
    logic signed [SAMPLE_W-1:0] rom_w;

    out_st_t out_d;
    out_st_t out_q;

    fsk_inc_table #(
        .SYM_W   (SYM_W),
        .PHASE_W (PHASE_W)
    ) u_tab (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .we_i    (tbl_we_i),
        .wsel_i  (tbl_sel_i),
        .wdata_i (tbl_step_i),
        .rsel_i  (sym_i),
        .step_o  (step_w)
    );

    fsk_phase_acc #(
        .PHASE_W (PHASE_W)
    ) u_acc (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .en_i   (en_i),
        .step_i (step_w),
        .acc_o  (acc_w)
    );

    fsk_sine_rom #(
        .ADDR_W   (ADDR_W),
        .SAMPLE_W (SAMPLE_W)
    ) u_rom (
        .clk_i  (clk_i),
        .addr_i (acc_w[PHASE_W-1 -: ADDR_W]),
        .data_o (rom_w)
    );

    always_comb begin
        out_d       = out_q;
        out_d.valid = en_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign valid_o  = out_q.valid;
    assign sample_o = out_q.valid ? rom_w : '0;

endmodule

// File: rtl/fsk_tone_gen_chk.sv
module fsk_tone_gen_chk #(
    parameter int PHASE_W  = 32,
    parameter int SAMPLE_W = 14
) (
    input logic                       clk_i,
    input logic                       rst_i,
    input logic                       en_i,
    input logic [PHASE_W-1:0]         acc_i,
    input logic [PHASE_W-1:0]         step_i,
    input logic                       valid_o,
    input logic signed [SAMPLE_W-1:0] sample_o
);
    localparam int AMP = (1 << (SAMPLE_W - 1)) - 1;

    AST_RESET_CLEARS: assert property (@(posedge clk_i) rst_i |=> (!valid_o && acc_i == '0)); // R1

    AST_VALID_FOLLOWS_EN: assert property (@(posedge clk_i) disable iff (rst_i)
        en_i |=> valid_o); // R2

    AST_ACC_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
        en_i |=> (acc_i == $past(acc_i) + $past(step_i))); // R3

    AST_ACC_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> $stable(acc_i)); // R5

    AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> (!valid_o && sample_o == '0)); // R5

    AST_SAMPLE_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o |-> (int'(sample_o) <= AMP && int'(sample_o) >= -AMP)); // R8

endmodule

bind fsk_tone_gen fsk_tone_gen_chk #(
    .PHASE_W  (PHASE_W),
    .SAMPLE_W (SAMPLE_W)
) u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .en_i     (en_i),
    .acc_i    (acc_w),
    .step_i   (step_w),
    .valid_o  (valid_o),
    .sample_o (sample_o)
);

// File: tb/fsk_tone_gen_tb.sv
`timescale 1ns/1ps
module fsk_tone_gen_tb;
    localparam int SYM_W    = 2;
    localparam int PHASE_W  = 32;
    localparam int ADDR_W   = 10;
    localparam int SAMPLE_W = 14;
    localparam int NSYM     = 1 << SYM_W;
    localparam int WATCHDOG = 50000;

    logic                       clk = 1'b0;
    logic                       rst_i = 1'b1;
    logic                       en_i = 1'b0;
    logic [SYM_W-1:0]           sym_i = '0;
    logic                       tbl_we_i = 1'b0;
    logic [SYM_W-1:0]           tbl_sel_i = '0;
    logic [PHASE_W-1:0]         tbl_step_i = '0;
    logic                       valid_o;
    logic signed [SAMPLE_W-1:0] sample_o;

    always #10 clk = ~clk;

    fsk_tone_gen #(
        .SYM_W    (SYM_W),
        .PHASE_W  (PHASE_W),
        .ADDR_W   (ADDR_W),
        .SAMPLE_W (SAMPLE_W)
    ) u_dut (
        .clk_i      (clk),
        .rst_i      (rst_i),
        .en_i       (en_i),
        .sym_i      (sym_i),
        .tbl_we_i   (tbl_we_i),
        .tbl_sel_i  (tbl_sel_i),
        .tbl_step_i (tbl_step_i),
        .valid_o    (valid_o),
        .sample_o   (sample_o)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    int    cycles   = 0;
    bit    done     = 0;
    string cur_req  = "R1";

    // behavioural model state
    longint unsigned m_acc = 0;
    longint unsigned m_tab [NSYM];
    bit              m_valid = 0;
    int              m_sample = 0;

    function automatic int ref_sine(input longint unsigned idx);
        real v;
        v = 8191.0 * $sin(2.0 * 3.14159265358979 * real'(idx) / 1024.0);
        if (v >= 0.0) return $rtoi(v + 0.5);
        return -$rtoi(-v + 0.5);
    endfunction

    // model advances on the rising edge, in the same order as the requirements
    always @(posedge clk) begin
        cycles++;
        if (rst_i) begin
            m_acc = 0; m_valid = 0; m_sample = 0;
            for (int i = 0; i < NSYM; i++) m_tab[i] = 0;
        end else begin
            m_valid  = en_i;
            m_sample = en_i ? ref_sine(m_acc >> 22) : 0;          // R2, R8
            if (en_i) m_acc = (m_acc + m_tab[sym_i]) & 64'hFFFF_FFFF; // R3, R4
            if (tbl_we_i) m_tab[tbl_sel_i] = longint'(tbl_step_i);   // R6: after use
        end
    end

    // compare one register stage after the stimulus edge
    always @(negedge clk) begin
        if (!done && cycles > 0) begin
            int diff;
            diff = int'(sample_o) - m_sample;
            n_checks++;
            if (valid_o !== m_valid || diff > 1 || diff < -1) begin
                n_fail++;
                $display("FAIL %s cycle %0d: valid=%0b sample=%0d expected valid=%0b sample=%0d",
                         cur_req, cycles, valid_o, sample_o, m_valid, m_sample);
            end
        end
    end

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_step(input int sel, input logic [PHASE_W-1:0] val);
        tbl_we_i = 1'b1; tbl_sel_i = SYM_W'(sel); tbl_step_i = val;
        @(negedge clk);
        tbl_we_i = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        @(negedge clk);
        // R1: reset state
        cur_req = "R1";
        wait_cycles(3);
        rst_i = 1'b0;
        // R2: enabled with all-zero table, phase stays at 0
        cur_req = "R2";
        en_i = 1'b1;
        wait_cycles(4);
        // R6: load table while idle; R5 covers idle output
        en_i = 1'b0;
        cur_req = "R6";
        write_step(0, 32'h0040_0000);   // one table entry per clock
        write_step(1, 32'h00C0_0000);   // three entries per clock
        write_step(2, 32'h0123_4567);   // fractional step
        write_step(3, 32'hFFC0_0000);   // minus one entry per clock
        cur_req = "R5";
        wait_cycles(3);
        // R8: full period and beyond on symbol 0
        cur_req = "R8";
        en_i = 1'b1; sym_i = 2'd0;
        wait_cycles(1100);
        // R7: each entry selected by its own index
        cur_req = "R7";
        for (int s = 1; s < NSYM; s++) begin
            sym_i = SYM_W'(s);
            wait_cycles(200);
        end
        // R3: wraparound with the backward step
        cur_req = "R3";
        sym_i = 2'd3;
        wait_cycles(300);
        // R4: symbol changes every clock, phase continues
        cur_req = "R4";
        for (int i = 0; i < 80; i++) begin
            sym_i = SYM_W'((i * 3 + i / 5) % NSYM);
            @(negedge clk);
        end
        // R5: enable gaps freeze the phase
        cur_req = "R5";
        for (int i = 0; i < 90; i++) begin
            en_i = (i % 3) != 0;
            sym_i = SYM_W'(i % NSYM);
            @(negedge clk);
        end
        en_i = 1'b1;
        // R6: rewrite the entry in use while running
        cur_req = "R6";
        sym_i = 2'd1;
        for (int i = 0; i < 12; i++) begin
            write_step(1, PHASE_W'(32'h0010_0000 * (i + 1)));
            wait_cycles(5);
        end
        // R1: reset in mid-run clears phase and table
        cur_req = "R1";
        rst_i = 1'b1;
        wait_cycles(2);
        rst_i = 1'b0;
        wait_cycles(5);
        finish_run();
    end

    initial begin
        wait (cycles >= WATCHDOG);
        @(negedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not end, actual %0d cycles expected fewer than %0d",
                     cycles, WATCHDOG);
            finish_run();
        end
    end

endmodule